// File: doc/BRIEF.md
# Buffered SPI Flash Master Engine

This block is a software-driven SPI master that moves data between a 64-byte on-chip buffer and a serial flash device. Software fills the buffer through a word-wide register bus, programs the serial clock timing, the length of the shift in bits, the chip-select behaviour and whether read data is captured, and then sets a start bit. The engine shifts the buffer out on MOSI, most significant bit first within each byte and in ascending byte order. If capture is enabled, it also samples MISO and writes each received bit back into the position of the bit that was sent in the same slot.

Completion is reported by a sticky flag that software must clear by writing it to zero. A hold option keeps chip select asserted after a chunk ends, so a frame longer than the buffer can be sent as several chunks that the flash device sees as one transfer. The serial clock runs in mode 0 or mode 2 only. Its period is set by a divider, and the length of its active phase is a separate count. A self-clearing soft reset returns all control state to its defaults.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, CS is high (low-active polarity), SCLK is 0, MOSI is 0, and the command (0x00) and status (0x30) registers read 0.
- R2: The buffer occupies byte offsets 0x40 to 0x7C as sixteen 32-bit words. Transfer byte k is bits [8*(k%4)+7 : 8*(k%4)] of the word at 0x40+4*(k/4), and words read back exactly as written.
- R3: Writing a word with bit 18 set to offset 0x00 starts a transfer. Bit 18 reads 1 while the transfer runs and 0 once it completes. A further start write during a transfer has no effect.
- R4: The engine shifts exactly F+1 bits, where F is the 9-bit field at bits 25:17 of offset 0x20. Bits go out MSB first within a byte and bytes go out in ascending order.
- R5: Bit 4 of offset 0x30 sets in the cycle the last bit completes. It stays set through idle cycles and through writes that carry a 1 in that bit, and clears when a write carries 0 there.
- R6: With bit 0 of offset 0x1C set, the bit on MISO at each leading SCLK edge replaces the transmitted bit in the same buffer position. With bit 0 clear, the buffer is left unchanged by a transfer.
- R7: Bit 23 of offset 0x2C set makes CS active-high, and clear makes it active-low. With bit 30 set, CS stays asserted after a transfer ends. With bit 30 clear, CS is deasserted when the transfer ends.
- R8: Bit 7 of offset 0x1C is the SCLK idle level. MOSI changes only on a trailing SCLK edge during a transfer, and MISO is captured on the leading edge.
- R9: Offset 0x18 holds divider N in bits 17:12, high count H in bits 11:6 and a low count in bits 5:0. The SCLK period is N+1 system clocks, with N=0 treated as 1. The active phase lasts min(H, N−1)+1 clocks. The low count is stored for readback only.
- R10: Writing bit 31 of offset 0x30 resets every configuration field, the done flag and the serial outputs to their reset values within two cycles. Bit 31 reads back as 0 afterwards.
- R11: Bus writes to the buffer window are ignored while a transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Byte offset of the register access, word aligned |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_cs | output | 1 | Chip select, polarity per configuration |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong bit index or phase count appears at the pins within a single SCLK period. It shows as a misplaced SCLK edge, a MOSI bit that does not match the buffer, or a MOSI change outside a trailing edge. A wrong end-of-transfer decision appears at the end of the chunk as an extra or missing SCLK pulse, a CS level that ignores the hold option, or a done flag that rises apart from busy falling. Errors in the capture path remain hidden until software reads the buffer back, so every transfer is followed by a readback of all sixteen words, including the bytes beyond the programmed length.

// File: rtl/spi_buf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the buffered SPI master: register offsets,
// field positions and the sequencer state type.
// Assumes a 7-bit byte address space with word-aligned accesses.
package spi_buf_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFF_CMD    = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_CLOCK  = 7'h18;
    localparam logic [ADDR_W-1:0] OFF_USER   = 7'h1C;
    localparam logic [ADDR_W-1:0] OFF_BITS   = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_CSCTL  = 7'h2C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 7'h30;

    localparam int CMD_GO_BIT     = 18;
    localparam int CLK_DIV_LSB    = 12;
    localparam int CLK_HI_LSB     = 6;
    localparam int CLK_LO_LSB     = 0;
    localparam int USER_RXEN_BIT  = 0;
    localparam int USER_CPOL_BIT  = 7;
    localparam int BITS_LSB       = 17;
    localparam int CS_POL_BIT     = 23;
    localparam int CS_HOLD_BIT    = 30;
    localparam int STAT_DONE_BIT  = 4;
    localparam int STAT_SRST_BIT  = 31;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_RUN  = 2'd2
    } sq_state_t;
endpackage

// File: rtl/spi_phase_gen.sv
`timescale 1ns/1ps
// Serial clock phase counter. Counts 0..N per SCLK period while run is
// high and flags the leading edge slot, the trailing edge slot, the
// period end and whether the clock is in its active phase.
// Assumes div and hi are quasi-static during a transfer.
module spi_phase_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    input  logic [CNT_W-1:0] hi,
    output logic             ph_end,
    output logic             lead_ev,
    output logic             trail_ev,
    output logic             active
);
    logic [CNT_W-1:0] ph_q;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] hi_eff;

    // Clamp the divider to at least 1 and the high count below it.
    always_comb begin
        div_eff = (div == '0) ? CNT_W'(1) : div;
        hi_eff  = (hi >= div_eff) ? div_eff - CNT_W'(1) : hi;
    end

    // Phase counter wraps at the effective divider.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q <= '0;
        end else if (ph_q >= div_eff) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + CNT_W'(1);
        end
    end

    // Edge slots derived from the current phase.
    always_comb begin
        ph_end   = run && (ph_q >= div_eff);
        lead_ev  = run && (ph_q == '0);
        trail_ev = run && (ph_q == hi_eff + CNT_W'(1));
        active   = (ph_q <= hi_eff);
    end
endmodule

// File: rtl/spi_buf_store.sv
`timescale 1ns/1ps
// Byte-organised transfer buffer. Offers a 32-bit word port for the bus,
// a single-bit read port for the shifter and a single-bit write port for
// captured data. Bit index i maps to byte i/8, bit 7-(i%8).
// Assumes the caller never asserts rx_we and wr_en in the same cycle
// with a meaning that matters; captured data wins.
module spi_buf_store #(
    parameter int BYTES  = 64,
    parameter int BIT_W  = 9,
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [31:0]       wr_data,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    input  logic [BIT_W-1:0]  tx_idx,
    output logic              tx_bit,
    input  logic              rx_we,
    input  logic [BIT_W-1:0]  rx_idx,
    input  logic              rx_bit
);
    localparam int BYTE_W = BIT_W - 3;

    logic [7:0] mem [BYTES];

    // Store a captured bit, otherwise a bus word.
    always_ff @(posedge clk) begin
        if (rx_we) begin
            mem[rx_idx[BIT_W-1:3]][~rx_idx[2:0]] <= rx_bit;
        end else if (wr_en) begin
            for (int l = 0; l < 4; l++) begin
                mem[{wr_word, 2'(l)}] <= wr_data[8*l +: 8];
            end
        end
    end

    // Assemble the word seen by the bus, lane l from byte 4*w+l.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [BYTE_W-1:0] bsel;
        assign bsel = {rd_word, 2'(g)};
        assign rd_data[8*g +: 8] = mem[bsel];
    end

    // Bit presented to the shifter.
    assign tx_bit = mem[tx_idx[BIT_W-1:3]][~tx_idx[2:0]];
endmodule

// File: rtl/spi_shift_seq.sv
`timescale 1ns/1ps
// Transfer sequencer. Asserts chip select, spends one idle SCLK period
// as MOSI setup, then shifts bit by bit: captures on the leading slot,
// advances MOSI on the trailing slot, counts bits on the period end.
// Assumes start is only meaningful in the idle state.
module spi_shift_seq #(
    parameter int BIT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BIT_W-1:0] last_in,
    input  logic             hold,
    input  logic             cpol,
    input  logic             ph_end,
    input  logic             lead_ev,
    input  logic             trail_ev,
    input  logic             active,
    input  logic             tx_bit,
    input  logic             miso,
    output logic             busy,
    output logic [BIT_W-1:0] idx,
    output logic [BIT_W-1:0] tx_idx,
    output logic             sample,
    output logic             rx_bit,
    output logic             done_ev,
    output logic             cs_act,
    output logic             sclk,
    output logic             mosi
);
    import spi_buf_pkg::*;

    sq_state_t        st_q;
    logic [BIT_W-1:0] idx_q;
    logic [BIT_W-1:0] last_q;
    logic             is_last;

    assign is_last = (idx_q == last_q);

    // Combinational handshakes towards the buffer and the flag logic.
    always_comb begin
        busy    = (st_q != SQ_IDLE);
        idx     = idx_q;
        tx_idx  = (st_q == SQ_IDLE) ? '0 : idx_q + BIT_W'(1);
        sample  = (st_q == SQ_RUN) && lead_ev;
        rx_bit  = miso;
        done_ev = (st_q == SQ_RUN) && ph_end && is_last;
    end

    // State, bit index, chip select and registered pin drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            idx_q  <= '0;
            last_q <= '0;
            cs_act <= 1'b0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
        end else begin
            sclk <= cpol ^ ((st_q == SQ_RUN) && active);
            case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        st_q   <= SQ_LEAD;
                        idx_q  <= '0;
                        last_q <= last_in;
                        cs_act <= 1'b1;
                        mosi   <= tx_bit;
                    end
                end
                SQ_LEAD: begin
                    if (ph_end) begin
                        st_q <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (trail_ev && !is_last) begin
                        mosi <= tx_bit;
                    end
                    if (ph_end) begin
                        if (is_last) begin
                            st_q   <= SQ_IDLE;
                            cs_act <= hold;
                        end else begin
                            idx_q <= idx_q + BIT_W'(1);
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_buf_master.sv
`timescale 1ns/1ps
// Buffered SPI master top. Holds the software-visible registers, decodes
// the word bus and ties together the phase generator, the sequencer and
// the transfer buffer. Assumes word-aligned accesses; unaligned ones are
// dropped.
module spi_buf_master #(
    parameter int BUF_BYTES = 64,
    parameter int CNT_W     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs,
    input  logic        spi_miso
);
    import spi_buf_pkg::*;

    localparam int BIT_W  = $clog2(BUF_BYTES * 8);
    localparam int WORDS  = BUF_BYTES / 4;
    localparam int WIDX_W = $clog2(WORDS);

    logic             srst_q;
    logic             core_rst_n;
    logic [CNT_W-1:0] div_q, hi_q, lo_q;
    logic             rxen_q, cpol_q, hold_q, cspol_q, done_q;
    logic [BIT_W-1:0] bits_q;

    logic             aligned, in_buf, wr_reg, start;
    logic             busy, sample, rx_bit, done_ev, cs_act, tx_bit;
    logic             ph_end, lead_ev, trail_ev, active;
    logic [BIT_W-1:0] bit_idx, tx_idx;
    logic [31:0]      buf_rdata;
    logic             unused_bus;

    assign unused_bus = ^{bus_wdata, bus_addr};
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign in_buf     = aligned && bus_addr[ADDR_W-1];
    assign wr_reg     = bus_we && aligned && !bus_addr[ADDR_W-1];
    assign start      = wr_reg && (bus_addr == OFF_CMD) && bus_wdata[CMD_GO_BIT] && !busy;
    assign core_rst_n = rst_n && !srst_q;

    // Soft reset pulse, one cycle wide, cleared on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
        end else begin
            srst_q <= wr_reg && (bus_addr == OFF_STATUS) && bus_wdata[STAT_SRST_BIT];
        end
    end

    // Configuration registers, written by the bus, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            div_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            rxen_q  <= 1'b0;
            cpol_q  <= 1'b0;
            bits_q  <= '0;
            hold_q  <= 1'b0;
            cspol_q <= 1'b0;
        end else if (wr_reg) begin
            case (bus_addr)
                OFF_CLOCK: begin
                    div_q <= bus_wdata[CLK_DIV_LSB +: CNT_W];
                    hi_q  <= bus_wdata[CLK_HI_LSB +: CNT_W];
                    lo_q  <= bus_wdata[CLK_LO_LSB +: CNT_W];
                end
                OFF_USER: begin
                    rxen_q <= bus_wdata[USER_RXEN_BIT];
                    cpol_q <= bus_wdata[USER_CPOL_BIT];
                end
                OFF_BITS:  bits_q <= bus_wdata[BITS_LSB +: BIT_W];
                OFF_CSCTL: begin
                    hold_q  <= bus_wdata[CS_HOLD_BIT];
                    cspol_q <= bus_wdata[CS_POL_BIT];
                end
                default: ;
            endcase
        end
    end

    // Sticky done flag: completion sets it, a zero written to it clears it.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            done_q <= 1'b0;
        end else if (done_ev) begin
            done_q <= 1'b1;
        end else if (wr_reg && (bus_addr == OFF_STATUS) && !bus_wdata[STAT_DONE_BIT]) begin
            done_q <= 1'b0;
        end
    end

    // Read multiplexer for registers and the buffer window.
    always_comb begin
        bus_rdata = '0;
        if (in_buf) begin
            bus_rdata = buf_rdata;
        end else if (aligned) begin
            case (bus_addr)
                OFF_CMD:   bus_rdata[CMD_GO_BIT] = busy;
                OFF_CLOCK: begin
                    bus_rdata[CLK_DIV_LSB +: CNT_W] = div_q;
                    bus_rdata[CLK_HI_LSB +: CNT_W]  = hi_q;
                    bus_rdata[CLK_LO_LSB +: CNT_W]  = lo_q;
                end
                OFF_USER: begin
                    bus_rdata[USER_RXEN_BIT] = rxen_q;
                    bus_rdata[USER_CPOL_BIT] = cpol_q;
                end
                OFF_BITS:  bus_rdata[BITS_LSB +: BIT_W] = bits_q;
                OFF_CSCTL: begin
                    bus_rdata[CS_HOLD_BIT] = hold_q;
                    bus_rdata[CS_POL_BIT]  = cspol_q;
                end
                OFF_STATUS: begin
                    bus_rdata[STAT_DONE_BIT] = done_q;
                    bus_rdata[STAT_SRST_BIT] = srst_q;
                end
                default: ;
            endcase
        end
    end

    spi_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .run      (busy),
        .div      (div_q),
        .hi       (hi_q),
        .ph_end   (ph_end),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev),
        .active   (active)
    );

    spi_shift_seq #(.BIT_W(BIT_W)) u_seq (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .start    (start),
        .last_in  (bits_q),
        .hold     (hold_q),
        .cpol     (cpol_q),
        .ph_end   (ph_end),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev),
        .active   (active),
        .tx_bit   (tx_bit),
        .miso     (spi_miso),
        .busy     (busy),
        .idx      (bit_idx),
        .tx_idx   (tx_idx),
        .sample   (sample),
        .rx_bit   (rx_bit),
        .done_ev  (done_ev),
        .cs_act   (cs_act),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi)
    );

    spi_buf_store #(.BYTES(BUF_BYTES), .BIT_W(BIT_W), .WIDX_W(WIDX_W)) u_store (
        .clk     (clk),
        .wr_en   (bus_we && in_buf && !busy),
        .wr_word (bus_addr[2 +: WIDX_W]),
        .wr_data (bus_wdata),
        .rd_word (bus_addr[2 +: WIDX_W]),
        .rd_data (buf_rdata),
        .tx_idx  (tx_idx),
        .tx_bit  (tx_bit),
        .rx_we   (sample && rxen_q),
        .rx_idx  (bit_idx),
        .rx_bit  (rx_bit)
    );

    // Pin polarity for chip select.
    assign spi_cs = cspol_q ? cs_act : !cs_act;
endmodule

// File: rtl/spi_buf_chk.sv
`timescale 1ns/1ps
// Protocol checker for the buffered SPI master, bound to the top.
// Assumes core_ok is low in any cycle where either reset is active.
module spi_buf_chk #(
    parameter int BIT_W = 9
) (
    input logic             clk,
    input logic             core_ok,
    input logic             busy,
    input logic             done_flag,
    input logic             cpol,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic [BIT_W-1:0] idx,
    input logic             bus_we,
    input logic [6:0]       bus_addr,
    input logic             go_bit
);
    // R3: an accepted start makes the engine busy on the next cycle.
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!core_ok)
        (bus_we && bus_addr == 7'h00 && go_bit && !busy) |=> busy);

    // R5: the done flag rises only together with the end of a transfer.
    p_done_at_end_r5: assert property (@(posedge clk) disable iff (!core_ok)
        $rose(done_flag) |-> $fell(busy));

    // R4: the bit index holds or steps by one while a transfer runs.
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!core_ok)
        (busy && $past(busy) && $past(core_ok)) |->
            (idx == $past(idx) || idx == $past(idx) + BIT_W'(1)));

    // R8: MOSI moves only where SCLK has just returned to idle.
    p_mosi_trail_r8: assert property (@(posedge clk) disable iff (!core_ok)
        (busy && $past(busy) && $past(core_ok) && spi_mosi != $past(spi_mosi)) |->
            (spi_sclk == cpol && $past(spi_sclk) != cpol));

    // R8: SCLK follows the idle level when no transfer ran in the last cycle.
    p_idle_level_r8: assert property (@(posedge clk) disable iff (!core_ok)
        ($past(core_ok) && !$past(busy)) |-> spi_sclk == $past(cpol));
endmodule

bind spi_buf_master spi_buf_chk #(.BIT_W(BIT_W)) u_chk (
    .clk       (clk),
    .core_ok   (core_rst_n),
    .busy      (busy),
    .done_flag (done_q),
    .cpol      (cpol_q),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .idx       (bit_idx),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .go_bit    (bus_wdata[18])
);

// File: tb/sim_spi_buf_master.sv
`timescale 1ns/1ps
module sim_spi_buf_master;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    typedef struct packed {
        logic [5:0] div;
        logic [5:0] hi;
        logic [6:0] nb;
        logic       cpol;
        logic       rx;
        logic       hold;
        logic       csh;
        logic [7:0] seed;
        logic [6:0] per;
        logic [6:0] hcyc;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{6'd3, 6'd1, 7'd4,  1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 7'd4, 7'd2},
        '{6'd1, 6'd0, 7'd1,  1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, 7'd2, 7'd1},
        '{6'd5, 6'd2, 7'd7,  1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 7'd6, 7'd3},
        '{6'd0, 6'd0, 7'd2,  1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 7'd2, 7'd1},
        '{6'd2, 6'd9, 7'd3,  1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 7'd3, 7'd2},
        '{6'd1, 6'd0, 7'd64, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 7'd2, 7'd1},
        '{6'd2, 6'd0, 7'd2,  1'b0, 1'b1, 1'b1, 1'b0, 8'h9E, 7'd3, 7'd1},
        '{6'd2, 6'd0, 7'd1,  1'b0, 1'b0, 1'b0, 1'b0, 8'h42, 7'd3, 7'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_cs;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // device model state
    logic       sl_on = 1'b0;
    logic       sl_cpol = 1'b0;
    logic       sl_csh = 1'b0;
    int         sl_cnt = 0;
    int         sl_csbad = 0;
    time        t_l0, t_l1, t_tr;
    logic [7:0] sl_rx [64];

    spi_buf_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] txb(logic [7:0] seed, int k);
        return seed + 8'(k * 13);
    endfunction
    function automatic logic [7:0] mb(int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction
    function automatic logic mbit(int k);
        logic [7:0] b;
        b = mb(k / 8);
        return b[7 - (k % 8)];
    endfunction

    // Mode 0/2 device: captures MOSI on leading edges, shifts MISO on trailing.
    always @(spi_sclk) begin
        if (sl_on) begin
            if (spi_sclk != sl_cpol) begin
                if (spi_cs != sl_csh) sl_csbad++;
                if (sl_cnt < 512) sl_rx[sl_cnt / 8][7 - (sl_cnt % 8)] = spi_mosi;
                if (sl_cnt == 0) t_l0 = $time;
                if (sl_cnt == 1) t_l1 = $time;
                sl_cnt++;
            end else begin
                if (sl_cnt == 1 && t_tr == 0) t_tr = $time;
                spi_miso = mbit(sl_cnt);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_CYCLES) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, WD_CYCLES);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int w = 0; w < 16; w++)
            wr(7'(8'h40 + 4*w), {txb(seed,4*w+3), txb(seed,4*w+2), txb(seed,4*w+1), txb(seed,4*w)});
    endtask

    task automatic setup(input vec_t v);
        wr(7'h1C, (32'(v.cpol) << 7) | 32'(v.rx));
        wr(7'h18, (32'(v.div) << 12) | (32'(v.hi) << 6) | 32'(v.div));
        wr(7'h20, (32'(v.nb) * 8 - 1) << 17);
        wr(7'h2C, (32'(v.hold) << 30) | (32'(v.csh) << 23));
        sl_cpol = v.cpol; sl_csh = v.csh;
        idle(3);
    endtask

    task automatic arm;
        sl_cnt = 0; sl_csbad = 0; t_l0 = 0; t_l1 = 0; t_tr = 0;
        spi_miso = mbit(0);
        sl_on = 1'b1;
    endtask

    task automatic wait_done(output logic ok);
        logic [31:0] d;
        ok = 1'b0;
        for (int i = 0; i < 20000 && !ok; i++) begin
            rd(7'h30, d);
            ok = d[4];
        end
        sl_on = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        logic ok;
        logic [31:0] d;
        int nbits;
        int mis;
        setup(v);
        fill(v.seed);
        arm();
        wr(7'h00, 32'h1 << 18);
        wait_done(ok);
        nbits = int'(v.nb) * 8;
        chk(ok, $sformatf("R5 done flag set v%0d", vi), ok, 1);
        chk(sl_cnt == nbits, $sformatf("R4 bit count v%0d", vi), sl_cnt, nbits);
        mis = 0;
        for (int k = 0; k < int'(v.nb); k++) if (sl_rx[k] != txb(v.seed, k)) mis++;
        chk(mis == 0, $sformatf("R4 R2 mosi bytes v%0d", vi), mis, 0);
        chk((t_l1 - t_l0) / CLK_PERIOD == v.per || v.nb == 0,
            $sformatf("R9 sclk period v%0d", vi), (t_l1 - t_l0) / CLK_PERIOD, v.per);
        chk((t_tr - t_l0) / CLK_PERIOD == v.hcyc,
            $sformatf("R9 active phase v%0d", vi), (t_tr - t_l0) / CLK_PERIOD, v.hcyc);
        chk(sl_csbad == 0, $sformatf("R7 cs asserted during v%0d", vi), sl_csbad, 0);
        chk(spi_cs == (v.hold ? v.csh : !v.csh),
            $sformatf("R7 cs after end v%0d", vi), spi_cs, v.hold ? v.csh : !v.csh);
        chk(spi_sclk == v.cpol, $sformatf("R8 sclk idle v%0d", vi), spi_sclk, v.cpol);
        rd(7'h00, d);
        chk(d[18] == 1'b0, $sformatf("R3 go bit cleared v%0d", vi), d[18], 0);
        mis = 0;
        for (int w = 0; w < 16; w++) begin
            logic [31:0] e;
            for (int l = 0; l < 4; l++) begin
                int k;
                k = 4*w + l;
                e[8*l +: 8] = (v.rx && k < int'(v.nb)) ? mb(k) : txb(v.seed, k);
            end
            rd(7'(8'h40 + 4*w), d);
            if (d != e) begin
                mis++;
                $display("  word %0d act=%h exp=%h", w, d, e);
            end
        end
        chk(mis == 0, $sformatf("R6 buffer readback v%0d", vi), mis, 0);
        idle(5);
        rd(7'h30, d);
        chk(d[4] == 1'b1, $sformatf("R5 done sticky v%0d", vi), d[4], 1);
        wr(7'h30, 32'h10);
        rd(7'h30, d);
        chk(d[4] == 1'b1, $sformatf("R5 write one keeps v%0d", vi), d[4], 1);
        wr(7'h30, 32'h0);
        rd(7'h30, d);
        chk(d[4] == 1'b0, $sformatf("R5 write zero clears v%0d", vi), d[4], 0);
    endtask

    initial begin
        logic [31:0] d;
        logic ok;
        int mis;
        idle(3);
        // R1: reset state
        chk(spi_cs == 1'b1, "R1 cs reset", spi_cs, 1);
        chk(spi_sclk == 1'b0, "R1 sclk reset", spi_sclk, 0);
        chk(spi_mosi == 1'b0, "R1 mosi reset", spi_mosi, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        rd(7'h00, d);
        chk(d == 32'h0, "R1 cmd reset", d, 0);
        rd(7'h30, d);
        chk(d == 32'h0, "R1 status reset", d, 0);

        // R2: word lanes read back as written
        wr(7'h44, 32'h8899AABB);
        rd(7'h44, d);
        chk(d == 32'h8899AABB, "R2 buffer word readback", d, 32'h8899AABB);

        foreach (VEC[i]) run_vec(VEC[i], i);

        // R3 and R11: start and buffer writes during a transfer are ignored
        setup('{6'd1, 6'd0, 7'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 7'd2, 7'd1});
        fill(8'h20);
        arm();
        wr(7'h00, 32'h1 << 18);
        idle(10);
        rd(7'h00, d);
        chk(d[18] == 1'b1, "R3 go bit reads busy", d[18], 1);
        wr(7'h40, 32'hDEADBEEF);
        wr(7'h00, 32'h1 << 18);
        wait_done(ok);
        chk(sl_cnt == 64, "R3 restart while busy ignored", sl_cnt, 64);
        mis = 0;
        for (int k = 0; k < 8; k++) if (sl_rx[k] != txb(8'h20, k)) mis++;
        chk(mis == 0, "R11 shifted bytes unchanged by bus write", mis, 0);
        rd(7'h40, d);
        chk(d == {txb(8'h20,3), txb(8'h20,2), txb(8'h20,1), txb(8'h20,0)},
            "R11 buffer write during transfer ignored", d,
            {txb(8'h20,3), txb(8'h20,2), txb(8'h20,1), txb(8'h20,0)});

        // R10: soft reset with done still set and non-default config
        wr(7'h1C, 32'h81);
        wr(7'h2C, 32'h1 << 23);
        idle(2);
        chk(spi_sclk == 1'b1 && spi_cs == 1'b0, "R10 pre-reset levels", {spi_sclk, spi_cs}, 2'b10);
        wr(7'h30, 32'h8000_0010);
        idle(2);
        chk(spi_sclk == 1'b0, "R10 sclk back to default", spi_sclk, 0);
        chk(spi_cs == 1'b1, "R10 cs back to default", spi_cs, 1);
        rd(7'h1C, d);
        chk(d == 32'h0, "R10 user cleared", d, 0);
        rd(7'h2C, d);
        chk(d == 32'h0, "R10 cs control cleared", d, 0);
        rd(7'h30, d);
        chk(d == 32'h0, "R10 status cleared and self-cleared", d, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule